// File: doc/BRIEF.md
# Dual-Width HDLC Frame Check Sequence Checker

This block validates the frame check sequence of received HDLC frames at byte level. A framing stage upstream delivers the in-frame bytes (address, control, payload and the trailing FCS bytes) with a valid strobe and markers for the first and last byte. The checker runs a reflected CCITT CRC over every byte, in either a 16-bit or a 32-bit width chosen per frame.

When a frame starts, the register is preset to all ones. Each accepted byte updates the register once, least significant bit first. After the last byte, the FCS bytes have also passed through the register. A good frame then leaves a fixed residue in the register. The block compares against this residue and emits a one-cycle pass or fail pulse. A frame too short to hold its FCS is always failed.

Top module: `hdlc_fcs_check`

## Requirements
- R1: With `mode32_i`=0 at frame start, the 16-bit register is preset to 0xFFFF. A frame whose register ends at 0xF0B8 after all bytes, FCS included, gives `crc_ok_o`.
- R2: With `mode32_i`=1 at frame start, the 32-bit register is preset to 0xFFFFFFFF. A frame whose register ends at 0xDEBB20E3 gives `crc_ok_o`.
- R3: A frame whose register does not end at the residue of its mode gives `crc_err_o`.
- R4: Bytes are taken LSB first through reflected polynomials: 0x8408 for the 16-bit width and 0xEDB88320 for the 32-bit width. The FCS is sent LSB byte first and is the complement of the payload CRC. The ASCII payload "123456789" followed by 0x6E,0x90 (16-bit) or by 0x26,0x39,0xF4,0xCB (32-bit) passes.
- R5: `mode32_i` is sampled only on the start byte. A change during a frame does not affect that frame.
- R6: Exactly one of `crc_ok_o`/`crc_err_o` is high for exactly one cycle. That cycle is the one after an accepted end byte. Both outputs are low at all other times.
- R7: A frame of fewer bytes than the FCS width (2 or 4) gives `crc_err_o`. This includes a single byte with start and end both set. A frame of exactly the FCS width can pass.
- R8: Bytes with `valid_i` low are ignored. Bytes with `valid_i` high but outside an open frame (no start byte seen) are ignored, and their end marker gives no pulse.
- R9: After reset, both result outputs are low.
- R10: A start byte while a frame is open abandons that frame without a result and begins a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode32_i | input | 1 | 1 = 32-bit CRC, 0 = 16-bit CRC; sampled at frame start |
| valid_i | input | 1 | Byte strobe |
| sof_i | input | 1 | Marks the first byte of a frame |
| eof_i | input | 1 | Marks the last byte of a frame |
| data_i | input | 8 | Received byte |
| crc_ok_o | output | 1 | One-cycle pass pulse |
| crc_err_o | output | 1 | One-cycle fail pulse |

## Verification
The assertions assume that the framing markers mean something only when `valid_i` is high. They also assume the mode level matters only on a start byte, so they check the latched mode for stability rather than the input. The stimulus drives every marker and the mode away from the clock edge. In gap cycles it deliberately leaves junk data and a stray end marker. It toggles the mode inside frames, so the properties see those idle-time values without treating them as frame events.

// File: rtl/hdlc_fcs_pkg.sv
package hdlc_fcs_pkg;
  localparam int unsigned CRC_W_MAX = 32;
  localparam int unsigned LEN_W     = 3;

  typedef enum logic {MODE_16 = 1'b0, MODE_32 = 1'b1} fcs_mode_e;

  localparam logic [15:0] POLY16    = 16'h8408;
  localparam logic [31:0] POLY32    = 32'hEDB8_8320;
  localparam logic [15:0] PRESET16  = 16'hFFFF;
  localparam logic [31:0] PRESET32  = 32'hFFFF_FFFF;
  localparam logic [15:0] RESIDUE16 = 16'hF0B8;
  localparam logic [31:0] RESIDUE32 = 32'hDEBB_20E3;
  localparam logic [LEN_W-1:0] FCS_BYTES16 = LEN_W'(2);
  localparam logic [LEN_W-1:0] FCS_BYTES32 = LEN_W'(4);
endpackage

// File: rtl/fcs_byte_step.sv
module fcs_byte_step #(
  parameter int unsigned W    = 16,
  parameter logic [W-1:0] POLY = '0
) (
  input  logic [W-1:0] crc_i,
  input  logic [7:0]   data_i,
  output logic [W-1:0] crc_o
);
  always_comb begin
    logic [W-1:0] c;
    logic         fb;
    c = crc_i;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ data_i[i];
      c  = c >> 1;
      if (fb) c = c ^ POLY;
    end
    crc_o = c;
  end
endmodule

// File: rtl/fcs_len_count.sv
module fcs_len_count #(
  parameter int unsigned LEN_W = 3,
  parameter int unsigned SAT   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             step_i,
  output logic [LEN_W-1:0] cnt_next_o
);
  localparam logic [LEN_W-1:0] SatVal = LEN_W'(SAT);
  logic [LEN_W-1:0] cnt_q;

  always_comb begin
    if (start_i)                        cnt_next_o = LEN_W'(1);
    else if (step_i && cnt_q < SatVal)  cnt_next_o = cnt_q + LEN_W'(1);
    else                                cnt_next_o = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_next_o;
  end
endmodule

// File: rtl/hdlc_fcs_check.sv
module hdlc_fcs_check
  import hdlc_fcs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode32_i,
  input  logic       valid_i,
  input  logic       sof_i,
  input  logic       eof_i,
  input  logic [7:0] data_i,
  output logic       crc_ok_o,
  output logic       crc_err_o
);
  logic [CRC_W_MAX-1:0] crc_q, crc_next, base32, step32;
  logic [15:0]          base16, step16;
  fcs_mode_e            mode_q, mode_eff;
  logic                 open_q, accept, start, done, match, long_enough;
  logic [LEN_W-1:0]     len_next;
  logic                 ok_q, err_q;

  assign start    = valid_i & sof_i;
  assign accept   = valid_i & (sof_i | open_q);
  assign done     = accept & eof_i;
  assign mode_eff = start ? fcs_mode_e'(mode32_i) : mode_q;
  assign base16   = start ? PRESET16 : crc_q[15:0];
  assign base32   = start ? PRESET32 : crc_q;

  fcs_byte_step #(.W(16), .POLY(POLY16)) u_step16 (
    .crc_i(base16), .data_i(data_i), .crc_o(step16));
  fcs_byte_step #(.W(32), .POLY(POLY32)) u_step32 (
    .crc_i(base32), .data_i(data_i), .crc_o(step32));

  fcs_len_count #(.LEN_W(LEN_W), .SAT(4)) u_len (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start),
    .step_i(accept), .cnt_next_o(len_next));

  always_comb begin
    if (mode_eff == MODE_32) begin
      crc_next    = step32;
      match       = (step32 == RESIDUE32);
      long_enough = (len_next >= FCS_BYTES32);
    end else begin
      crc_next    = {16'h0, step16};
      match       = (step16 == RESIDUE16);
      long_enough = (len_next >= FCS_BYTES16);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q  <= '0;
      mode_q <= MODE_16;
      open_q <= 1'b0;
      ok_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (accept) begin
        crc_q  <= crc_next;
        mode_q <= mode_eff;
        open_q <= ~eof_i;
      end
      ok_q  <= done & match & long_enough;
      err_q <= done & ~(match & long_enough);
    end
  end

  assign crc_ok_o  = ok_q;
  assign crc_err_o = err_q;
endmodule

// File: rtl/hdlc_fcs_check_sva.sv
module hdlc_fcs_check_sva (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic sof_i,
  input logic eof_i,
  input logic open_i,
  input logic mode_q_i,
  input logic crc_ok_o,
  input logic crc_err_o
);
  assert_onehot_result_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({crc_ok_o, crc_err_o}));

  assert_pulse_after_eof_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && eof_i && (sof_i || open_i)) |=> (crc_ok_o || crc_err_o));

  assert_no_stray_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && eof_i && (sof_i || open_i)) |=> !(crc_ok_o || crc_err_o));

  assert_single_byte_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sof_i && eof_i) |=> crc_err_o);

  assert_mode_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_i && !(valid_i && sof_i)) |=> $stable(mode_q_i));
endmodule

bind hdlc_fcs_check hdlc_fcs_check_sva u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .sof_i(sof_i),
  .eof_i(eof_i), .open_i(open_q), .mode_q_i(mode_q),
  .crc_ok_o(crc_ok_o), .crc_err_o(crc_err_o));

// File: tb/hdlc_fcs_check_tb.sv
module hdlc_fcs_check_tb;
  logic clk = 0, rst_n = 0;
  logic mode32 = 0, valid = 0, sof = 0, eof = 0;
  logic [7:0] data = 0;
  logic ok, err;
  int n_chk = 0, n_bad = 0, cycles = 0;
  logic [7:0] fbuf [0:63];
  int flen;

  always #5 clk = ~clk;

  hdlc_fcs_check u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode32_i(mode32), .valid_i(valid),
    .sof_i(sof), .eof_i(eof), .data_i(data), .crc_ok_o(ok), .crc_err_o(err));

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  task automatic check(input logic [1:0] act, input logic [1:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual ok/err=%b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input bit m32, input int len);
    logic [31:0] c = m32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    logic [31:0] p = m32 ? 32'hEDB8_8320 : 32'h0000_8408;
    for (int b = 0; b < len; b++)
      for (int i = 0; i < 8; i++) begin
        logic fb = c[0] ^ fbuf[b][i];
        c = c >> 1;
        if (fb) c = c ^ p;
      end
    return ~c;
  endfunction

  task automatic add_fcs(input bit m32);
    logic [31:0] f = ref_crc(m32, flen);
    for (int i = 0; i < (m32 ? 4 : 2); i++) begin
      fbuf[flen] = f[8*i +: 8];
      flen++;
    end
  endtask

  task automatic drive(input logic [7:0] d, input logic s, input logic e, input logic v);
    @(negedge clk);
    valid = v; data = d; sof = s; eof = e;
  endtask

  // idle then sample the cycle after the last byte
  task automatic end_and_check(input logic [1:0] exp, input string req);
    drive(8'h00, 0, 0, 0);
    check({ok, err}, exp, req);
    @(negedge clk);
    check({ok, err}, 2'b00, "R6");
  endtask

  task automatic send_frame(input bit m32, input bit gaps);
    mode32 = m32;
    for (int i = 0; i < flen; i++) begin
      drive(fbuf[i], i == 0, i == flen - 1, 1);
      if (gaps && i != flen - 1) drive(8'hA5, 1'b0, 1'b1, 1'b0);
    end
  endtask

  task automatic t_known(input bit m32);
    string s = "123456789";
    for (int i = 0; i < 9; i++) fbuf[i] = s[i];
    if (m32) begin
      fbuf[9] = 8'h26; fbuf[10] = 8'h39; fbuf[11] = 8'hF4; fbuf[12] = 8'hCB; flen = 13;
    end else begin
      fbuf[9] = 8'h6E; fbuf[10] = 8'h90; flen = 11;
    end
    send_frame(m32, 0);
    end_and_check(2'b10, "R4");
  endtask

  task automatic t_patterns(input bit m32);
    for (int p = 0; p < 3; p++) begin
      flen = 5 + 7 * p;
      for (int i = 0; i < flen; i++)
        fbuf[i] = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : 8'(i * 37 + 11);
      add_fcs(m32);
      send_frame(m32, 0);
      end_and_check(2'b10, m32 ? "R2" : "R1");
    end
  endtask

  task automatic t_corrupt(input bit m32);
    flen = 6;
    for (int i = 0; i < flen; i++) fbuf[i] = 8'(i + 3);
    add_fcs(m32);
    fbuf[2] ^= 8'h10;
    send_frame(m32, 0);
    end_and_check(2'b01, "R3");
  endtask

  task automatic t_lengths();
    flen = 0; add_fcs(0); send_frame(0, 0); end_and_check(2'b10, "R7");
    flen = 0; add_fcs(1); send_frame(1, 0); end_and_check(2'b10, "R7");
    flen = 1; fbuf[0] = 8'h3C; send_frame(0, 0); end_and_check(2'b01, "R7");
    flen = 3; fbuf[0] = 8'h00; fbuf[1] = 8'h00; fbuf[2] = 8'h00;
    send_frame(1, 0); end_and_check(2'b01, "R7");
  endtask

  task automatic t_mode_mid();
    flen = 8;
    for (int i = 0; i < flen; i++) fbuf[i] = 8'(8'hC1 ^ i);
    add_fcs(0);
    mode32 = 0;
    for (int i = 0; i < flen; i++) begin
      drive(fbuf[i], i == 0, i == flen - 1, 1);
      if (i > 0) mode32 = 1;
    end
    end_and_check(2'b10, "R5");
    mode32 = 0;
  endtask

  task automatic t_ignore();
    flen = 7;
    for (int i = 0; i < flen; i++) fbuf[i] = 8'(i * 91);
    add_fcs(1);
    send_frame(1, 1);
    end_and_check(2'b10, "R8");
    drive(8'h55, 0, 0, 1);
    drive(8'h66, 0, 1, 1);
    drive(8'h00, 0, 0, 0);
    check({ok, err}, 2'b00, "R8");
  endtask

  task automatic t_restart();
    drive(8'h12, 1, 0, 1);
    drive(8'h34, 0, 0, 1);
    flen = 4;
    for (int i = 0; i < flen; i++) fbuf[i] = 8'(8'h70 + i);
    add_fcs(0);
    send_frame(0, 0);
    end_and_check(2'b10, "R10");
  endtask

  initial begin
    #1;
    check({ok, err}, 2'b00, "R9");
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check({ok, err}, 2'b00, "R9");
    t_known(0);
    t_known(1);
    t_patterns(0);
    t_patterns(1);
    t_corrupt(0);
    t_corrupt(1);
    t_lengths();
    t_mode_mid();
    t_ignore();
    t_restart();
    finish_run();
  end
endmodule